// File: doc/BRIEF.md
# Burst Memory Access Sequencer

The sequencer turns one system-side burst request into the cycle-level pin activity needed by a synchronous, burst-capable external memory. This covers NOR-style parts and self-refreshing SRAM-compatible arrays. A request carries a start word address, a length code, a direction and a wrap flag. The sequencer opens the device with chip select and an address-valid cycle. It then steps the word address once per data beat and drives the output-enable or write strobe. Finally it closes the device again.

Beats normally follow one another at a fixed, statically configured spacing. When wait monitoring is enabled, the device can stretch any beat through its wait pin, including the first beat. This covers parts that pause an access to finish an internal refresh. Requests longer than the configured device page are clipped to the page and flagged. A linear request whose start address is not a multiple of its length is refused with an error pulse. Wrapping requests step around inside the aligned block of their effective length.

Top module: `burst_seq`

## Requirements
- R1: After reset, and while reset is held, `req_ready_o` is 1, `busy_o`, `rdata_valid_o` and `err_o` are 0, and `mem_cs_no`, `mem_adv_no`, `mem_oe_no` and `mem_we_no` are all 1.
- R2: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 1 only while the sequencer is idle, and `busy_o` is 1 from the cycle after acceptance until the sequencer is idle again.
- R3: The length code on `req_len_i` and `cfg_page_i` is 0 for 1 word, 1 for 4 words, 2 for 8 words and 3 for 16 words. A linear burst (`req_wrap_i`=0) performs beats at addresses start, start+1, start+2, and so on.
- R4: A wrapping burst (`req_wrap_i`=1) keeps the upper address bits of the start and increments only the low bits that span the effective length. For example, 8 words from word 0x25 visit 0x25,0x26,0x27,0x20,0x21,0x22,0x23,0x24.
- R5: The effective length is the smaller of the requested length and `cfg_page_i`, and exactly that many beats are performed. `trunc_o` becomes 1 when a request longer than the page is accepted. It holds that value until the next acceptance.
- R6: A linear request whose start address has any of its low log2(length) bits set performs no beat. The chip select stays at 1, and `err_o` is 1 for exactly the cycle after acceptance.
- R7: With wait monitoring off, the first beat completes `cfg_gap_i`+1 cycles after the address-valid cycle, and later beats complete every `cfg_gap_i`+1 cycles.
- R8: With `cfg_wait_en_i`=1, a beat cannot complete in a cycle where `mem_wait_i` is 1, and the beat address stays put. This holds for any beat, including the first. With `cfg_wait_en_i`=0, `mem_wait_i` has no effect.
- R9: `mem_cs_no` falls together with a single address-valid cycle (`mem_adv_no`=0, address = start) that comes before the first beat. It stays 0 for one cycle after the last beat, with both strobes at 1. Once it rises, it stays 1 for at least one cycle.
- R10: In a write burst, `mem_we_no` is 0 during the beat phase. `wdata_ready_o` is 1 for the single cycle in which each beat completes, and in that cycle `mem_wdata_o` equals `wdata_i`.
- R11: In a read burst, `mem_rdata_i` is captured when each beat completes. It appears on `rdata_o` with `rdata_valid_o` high for one cycle, in the next cycle.
- R12: `mem_oe_no` is 0 only in read beats and `mem_we_no` only in write beats. They are never 0 together, and neither is 0 while `mem_cs_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Burst request present |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| req_addr_i | input | ADDR_W | Start word address |
| req_len_i | input | 2 | Requested length code |
| req_wrap_i | input | 1 | 1 = wrapping burst, 0 = linear |
| req_write_i | input | 1 | 1 = write burst, 0 = read burst |
| cfg_page_i | input | 2 | Device page length code (static) |
| cfg_gap_i | input | GAP_W | Extra cycles between beats (static) |
| cfg_wait_en_i | input | 1 | Enable beat stalling by the wait pin |
| wdata_i | input | DATA_W | Write data for the current beat |
| wdata_ready_o | output | 1 | Current write word consumed this cycle |
| rdata_o | output | DATA_W | Read data of the last completed read beat |
| rdata_valid_o | output | 1 | `rdata_o` valid this cycle |
| busy_o | output | 1 | Burst or error response in progress |
| trunc_o | output | 1 | Last accepted request was clipped to the page |
| err_o | output | 1 | Misaligned linear request refused |
| mem_addr_o | output | ADDR_W | Word address to the device |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_adv_no | output | 1 | Address valid, active low |
| mem_oe_no | output | 1 | Output enable (read strobe), active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_wait_i | input | 1 | Device wait, active high |
| mem_wdata_o | output | DATA_W | Write data to the device |
| mem_rdata_i | input | DATA_W | Read data from the device |

## Verification
Every cycle, the properties check the pin rules. Idle means deselected. Strobes are exclusive and appear only under chip select. Chip select opens with an address-valid cycle and stays high for at least one cycle after closing. An asserted wait with monitoring on freezes the beat address and blocks write consumption. Read-valid follows an output-enable beat, and an error never selects the device. What no single-cycle property can show is the content of the burst: the wrapped or linear address order, the clipped beat count, the exact beat spacing for each gap value, the position of the first beat after a wait stall, and the refusal of misaligned linear starts. The bench scenarios cover these by comparing the captured beat addresses and cycles against values worked out from the requirements.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BEAT,
    ST_TAIL,
    ST_ERR
  } seq_state_e;

  localparam int unsigned LEN_CODE_W = 2;
  localparam int unsigned BEAT_IDX_W = 4;   // up to 16 beats

  // length code -> word count
  function automatic logic [BEAT_IDX_W:0] code_words(input logic [LEN_CODE_W-1:0] code);
    logic [BEAT_IDX_W:0] w;
    unique case (code)
      2'd0:    w = 5'd1;
      2'd1:    w = 5'd4;
      2'd2:    w = 5'd8;
      default: w = 5'd16;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned IDX_W        = BEAT_IDX_W,
  parameter bit          SUPPORT_WRAP = 1'b1
) (
  input  logic [ADDR_W-1:0]     base_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [LEN_CODE_W-1:0] len_i,
  input  logic                  wrap_i,
  output logic [ADDR_W-1:0]     addr_o
);

  logic [ADDR_W-1:0] span_mask;
  logic [ADDR_W-1:0] lin_addr;

  assign span_mask = ADDR_W'(code_words(len_i) - 5'd1);
  assign lin_addr  = base_i + ADDR_W'(idx_i);

  generate
    if (SUPPORT_WRAP) begin : g_wrap
      // upper bits frozen, low bits roll within the aligned block
      assign addr_o = wrap_i ? ((base_i & ~span_mask) | (lin_addr & span_mask)) : lin_addr;
    end else begin : g_lin
      assign addr_o = lin_addr;
    end
  endgenerate

endmodule

// File: rtl/burst_beat_timer.sv
module burst_beat_timer #(
  parameter int unsigned GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             active_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             wait_en_i,
  input  logic             wait_i,
  output logic             fire_o
);

  logic [GAP_W-1:0] cnt_q;
  logic             hold;

  assign hold   = wait_en_i & wait_i;
  assign fire_o = active_i & (cnt_q == '0) & ~hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i || fire_o) begin
      cnt_q <= gap_i;
    end else if (active_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - GAP_W'(1);
    end
  end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = BEAT_IDX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [LEN_CODE_W-1:0] req_len_i,
  input  logic                  req_wrap_i,
  input  logic                  req_write_i,
  input  logic [LEN_CODE_W-1:0] cfg_page_i,
  input  logic                  fire_i,
  output seq_state_e            state_o,
  output logic [ADDR_W-1:0]     base_o,
  output logic [LEN_CODE_W-1:0] len_o,
  output logic                  wrap_o,
  output logic                  write_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic                  trunc_o
);

  seq_state_e            state_q, state_d;
  logic [ADDR_W-1:0]     base_q;
  logic [LEN_CODE_W-1:0] len_q;
  logic                  wrap_q, write_q, trunc_q;
  logic [IDX_W-1:0]      idx_q;

  logic [ADDR_W-1:0] align_mask;
  logic              accept, misalign, over_page, last_beat;

  assign accept     = (state_q == ST_IDLE) && req_valid_i;
  assign align_mask = ADDR_W'(code_words(req_len_i) - 5'd1);
  assign misalign   = !req_wrap_i && (|(req_addr_i & align_mask));
  assign over_page  = req_len_i > cfg_page_i;
  assign last_beat  = idx_q == IDX_W'(code_words(len_q) - 5'd1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = misalign ? ST_ERR : ST_LEAD;
      ST_LEAD: state_d = ST_BEAT;
      ST_BEAT: if (fire_i && last_beat) state_d = ST_TAIL;
      ST_TAIL: state_d = ST_IDLE;
      ST_ERR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      len_q   <= '0;
      wrap_q  <= 1'b0;
      write_q <= 1'b0;
      trunc_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        base_q  <= req_addr_i;
        len_q   <= over_page ? cfg_page_i : req_len_i;
        wrap_q  <= req_wrap_i;
        write_q <= req_write_i;
        trunc_q <= over_page && !misalign;
        idx_q   <= '0;
      end else if ((state_q == ST_BEAT) && fire_i && !last_beat) begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign state_o = state_q;
  assign base_o  = base_q;
  assign len_o   = len_q;
  assign wrap_o  = wrap_q;
  assign write_o = write_q;
  assign idx_o   = idx_q;
  assign trunc_o = trunc_q;

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GAP_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_len_i,
  input  logic              req_wrap_i,
  input  logic              req_write_i,
  input  logic [1:0]        cfg_page_i,
  input  logic [GAP_W-1:0]  cfg_gap_i,
  input  logic              cfg_wait_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wdata_ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              busy_o,
  output logic              trunc_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_adv_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  input  logic              mem_wait_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int unsigned IDX_W = BEAT_IDX_W;

  seq_state_e            state;
  logic [ADDR_W-1:0]     base;
  logic [LEN_CODE_W-1:0] eff_len;
  logic                  wrap, is_write, fire, in_beat;
  logic [IDX_W-1:0]      idx;
  logic [DATA_W-1:0]     rdata_q;
  logic                  rvalid_q;

  burst_ctrl #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .req_wrap_i  (req_wrap_i),
    .req_write_i (req_write_i),
    .cfg_page_i  (cfg_page_i),
    .fire_i      (fire),
    .state_o     (state),
    .base_o      (base),
    .len_o       (eff_len),
    .wrap_o      (wrap),
    .write_o     (is_write),
    .idx_o       (idx),
    .trunc_o     (trunc_o)
  );

  assign in_beat = state == ST_BEAT;

  burst_beat_timer #(
    .GAP_W (GAP_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state == ST_LEAD),
    .active_i  (in_beat),
    .gap_i     (cfg_gap_i),
    .wait_en_i (cfg_wait_en_i),
    .wait_i    (mem_wait_i),
    .fire_o    (fire)
  );

  burst_addr_gen #(
    .ADDR_W       (ADDR_W),
    .IDX_W        (IDX_W),
    .SUPPORT_WRAP (1'b1)
  ) u_addr (
    .base_i (base),
    .idx_i  (idx),
    .len_i  (eff_len),
    .wrap_i (wrap),
    .addr_o (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= fire && !is_write;
      if (fire && !is_write) rdata_q <= mem_rdata_i;
    end
  end

  assign req_ready_o   = state == ST_IDLE;
  assign busy_o        = state != ST_IDLE;
  assign err_o         = state == ST_ERR;
  assign mem_cs_no     = !((state == ST_LEAD) || in_beat || (state == ST_TAIL));
  assign mem_adv_no    = state != ST_LEAD;
  assign mem_oe_no     = !(in_beat && !is_write);
  assign mem_we_no     = !(in_beat && is_write);
  assign wdata_ready_o = fire && is_write;
  assign mem_wdata_o   = wdata_i;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              cfg_wait_en_i,
  input logic              mem_wait_i,
  input logic              mem_cs_no,
  input logic              mem_adv_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              wdata_ready_o,
  input logic              rdata_valid_o,
  input logic              err_o
);

  assert_idle_deselect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_no && mem_oe_no && mem_we_no));

  assert_accept_leaves_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_err_deselect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> mem_cs_no);

  assert_wait_freezes_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wait_en_i && mem_wait_i && (!mem_oe_no || !mem_we_no))
      |=> ($stable(mem_addr_o) && !mem_cs_no && (!mem_oe_no || !mem_we_no)));

  assert_wait_blocks_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wait_en_i && mem_wait_i) |-> !wdata_ready_o);

  assert_select_opens_adv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_cs_no) |-> (!mem_adv_no && mem_oe_no && mem_we_no));

  assert_select_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_cs_no) |=> mem_cs_no);

  assert_write_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_ready_o |-> !mem_we_no);

  assert_read_follows_oe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> $past(!mem_oe_no));

  assert_strobe_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  assert_strobe_selected_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> !mem_cs_no);

endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .cfg_wait_en_i (cfg_wait_en_i),
  .mem_wait_i    (mem_wait_i),
  .mem_cs_no     (mem_cs_no),
  .mem_adv_no    (mem_adv_no),
  .mem_oe_no     (mem_oe_no),
  .mem_we_no     (mem_we_no),
  .mem_addr_o    (mem_addr_o),
  .wdata_ready_o (wdata_ready_o),
  .rdata_valid_o (rdata_valid_o),
  .err_o         (err_o)
);

// File: tb/burst_seq_bench.sv
`timescale 1ns/1ps
module burst_seq_bench;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int GW = 4;
  localparam logic [15:0] KEY = 16'h5A5A;

  typedef struct packed {
    logic [15:0] a;
    logic [1:0]  len;
    logic        wrp;
    logic        wr;
    logic [1:0]  pg;
    logic [3:0]  gap;
    logic [4:0]  n;
    logic        tr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'h0010, 2'd1, 1'b0, 1'b0, 2'd3, 4'd0, 5'd4,  1'b0},
    '{16'h0025, 2'd2, 1'b1, 1'b0, 2'd3, 4'd1, 5'd8,  1'b0},
    '{16'h0040, 2'd3, 1'b0, 1'b1, 2'd2, 4'd0, 5'd8,  1'b1},
    '{16'h0033, 2'd0, 1'b0, 1'b1, 2'd3, 4'd2, 5'd1,  1'b0},
    '{16'h0107, 2'd3, 1'b1, 1'b0, 2'd1, 4'd0, 5'd4,  1'b1},
    '{16'h0080, 2'd3, 1'b0, 1'b0, 2'd3, 4'd3, 5'd16, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]    req_len_i = '0;
  logic          req_wrap_i = 1'b0;
  logic          req_write_i = 1'b0;
  logic [1:0]    cfg_page_i = 2'd3;
  logic [GW-1:0] cfg_gap_i = '0;
  logic          cfg_wait_en_i = 1'b0;
  logic [DW-1:0] wdata_i = 16'hC000;
  logic          wdata_ready_o;
  logic [DW-1:0] rdata_o;
  logic          rdata_valid_o, busy_o, trunc_o, err_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_cs_no, mem_adv_no, mem_oe_no, mem_we_no;
  logic          mem_wait_i = 1'b0;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i;

  assign mem_rdata_i = mem_addr_o ^ KEY;

  always #2.5 clk = ~clk;

  burst_seq #(.ADDR_W(AW), .DATA_W(DW), .GAP_W(GW)) u_burst_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i), .req_wrap_i(req_wrap_i),
    .req_write_i(req_write_i), .cfg_page_i(cfg_page_i), .cfg_gap_i(cfg_gap_i),
    .cfg_wait_en_i(cfg_wait_en_i), .wdata_i(wdata_i), .wdata_ready_o(wdata_ready_o),
    .rdata_o(rdata_o), .rdata_valid_o(rdata_valid_o), .busy_o(busy_o),
    .trunc_o(trunc_o), .err_o(err_o), .mem_addr_o(mem_addr_o),
    .mem_cs_no(mem_cs_no), .mem_adv_no(mem_adv_no), .mem_oe_no(mem_oe_no),
    .mem_we_no(mem_we_no), .mem_wait_i(mem_wait_i), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int cap_a [32];
  int cap_c [32];
  int cap_n;
  bit lead_ok, tail_ok, wr_ok, err_seen, err_cs;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int words(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int exp_addr(input int a, input logic [1:0] len, input logic wrp,
                                  input logic [1:0] pg, input int k);
    int w;
    w = words((len < pg) ? len : pg);
    if (wrp) return (a & ~(w - 1)) | ((a + k) & (w - 1));
    return (a + k) & 32'hFFFF;
  endfunction

  function automatic logic wait_at(input int mode, input int c);
    if (mode == 1) return (c >= 1) && (c <= 6);
    if (mode == 2) return (c % 3) == 0;
    return 1'b0;
  endfunction

  // cycle c = c-th interval after the accepting edge
  task automatic run(input logic [15:0] a, input logic [1:0] len, input logic wrp,
                     input logic wr, input logic [1:0] pg, input logic [3:0] gap,
                     input logic wen, input int wmode);
    int c;
    bit prev_cs_low, prev_str_off;
    @(negedge clk);
    req_addr_i = a; req_len_i = len; req_wrap_i = wrp; req_write_i = wr;
    cfg_page_i = pg; cfg_gap_i = gap; cfg_wait_en_i = wen; mem_wait_i = 1'b0;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    cap_n = 0; lead_ok = 1'b0; tail_ok = 1'b0; wr_ok = 1'b1;
    err_seen = 1'b0; err_cs = 1'b0;
    prev_cs_low = 1'b0; prev_str_off = 1'b0;
    c = 1;
    while (c < 600) begin
      mem_wait_i = wait_at(wmode, c);
      #1;
      if (c == 1) begin
        lead_ok  = !mem_cs_no && !mem_adv_no && (mem_addr_o == a);
        err_seen = err_o;
        err_cs   = mem_cs_no;
      end
      if (wr && wdata_ready_o && cap_n < 32) begin
        cap_a[cap_n] = int'(mem_addr_o);
        cap_c[cap_n] = c;
        if (mem_we_no || (mem_wdata_o != wdata_i)) wr_ok = 1'b0;
        cap_n++;
        wdata_i = wdata_i + 16'd1;
      end
      if (!wr && rdata_valid_o && cap_n < 32) begin
        cap_a[cap_n] = int'(rdata_o ^ KEY);
        cap_c[cap_n] = c - 1;
        cap_n++;
      end
      if (!busy_o) begin
        tail_ok = prev_cs_low && prev_str_off;
        break;
      end
      prev_cs_low  = !mem_cs_no;
      prev_str_off = mem_oe_no && mem_we_no;
      c++;
      @(negedge clk);
    end
    mem_wait_i = 1'b0;
  endtask

  task automatic check_seq(input logic [15:0] a, input logic [1:0] len, input logic wrp,
                           input logic [1:0] pg, input int n_exp);
    for (int k = 0; k < n_exp && k < cap_n; k++) begin
      chk(cap_a[k] == exp_addr(int'(a), len, wrp, pg, k),
          wrp ? "R4 wrap address" : "R3 linear address",
          cap_a[k], exp_addr(int'(a), len, wrp, pg, k));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(req_ready_o && !busy_o && !rdata_valid_o && !err_o, "R1 reset handshake",
        int'({req_ready_o, busy_o, rdata_valid_o, err_o}), 8);
    chk(mem_cs_no && mem_adv_no && mem_oe_no && mem_we_no, "R1 reset pins",
        int'({mem_cs_no, mem_adv_no, mem_oe_no, mem_we_no}), 15);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int ok_gap;
      t = VECS[v];
      run(t.a, t.len, t.wrp, t.wr, t.pg, t.gap, 1'b0, 0);
      chk(cap_n == int'(t.n), "R5 beat count", cap_n, int'(t.n));
      check_seq(t.a, t.len, t.wrp, t.pg, int'(t.n));
      chk(trunc_o == t.tr, "R5 trunc flag", int'(trunc_o), int'(t.tr));
      chk(lead_ok, "R9 lead cycle", int'(lead_ok), 1);
      chk(tail_ok, "R9 tail cycle", int'(tail_ok), 1);
      ok_gap = (cap_n > 0) && (cap_c[0] == 2 + int'(t.gap));
      for (int k = 1; k < cap_n; k++)
        if (cap_c[k] - cap_c[k-1] != int'(t.gap) + 1) ok_gap = 0;
      chk(ok_gap != 0, "R7 beat spacing", cap_n > 0 ? cap_c[0] : -1, 2 + int'(t.gap));
      if (t.wr) chk(wr_ok, "R10 write data handoff", int'(wr_ok), 1);
      else      chk(cap_n > 0, "R11 read data returned", cap_n, int'(t.n));
    end

    // R6: misaligned linear start refused
    run(16'h0012, 2'd1, 1'b0, 1'b0, 2'd3, 4'd0, 1'b0, 0);
    chk(err_seen && err_cs, "R6 error pulse deselected", int'({err_seen, err_cs}), 3);
    chk(cap_n == 0, "R6 no beats", cap_n, 0);
    @(negedge clk);
    chk(!err_o && req_ready_o, "R6 error single cycle", int'(err_o), 0);

    // R8: wait from cycle 1 to 6 stalls first write beat to cycle 7
    run(16'h0200, 2'd1, 1'b0, 1'b1, 2'd3, 4'd0, 1'b1, 1);
    chk(cap_n == 4 && cap_c[0] == 7, "R8 first beat held by wait", cap_c[0], 7);
    check_seq(16'h0200, 2'd1, 1'b0, 2'd3, 4);

    // R8: wait every third cycle during a read burst
    run(16'h0300, 2'd2, 1'b0, 1'b0, 2'd3, 4'd0, 1'b1, 2);
    chk(cap_n == 8, "R8 beats under periodic wait", cap_n, 8);
    begin
      int c, k;
      c = 2; k = 0;
      while (k < cap_n) begin
        if ((c % 3) != 0) begin
          chk(cap_c[k] == c, "R8 beat cycle under wait", cap_c[k], c);
          k++;
        end
        c++;
      end
    end
    check_seq(16'h0300, 2'd2, 1'b0, 2'd3, 8);
    chk(trunc_o == 1'b0, "R5 trunc cleared", int'(trunc_o), 0);

    // R8: wait ignored when monitoring off
    run(16'h0400, 2'd1, 1'b0, 1'b1, 2'd3, 4'd1, 1'b0, 1);
    chk(cap_n == 4 && cap_c[0] == 3, "R8 wait ignored when disabled", cap_c[0], 3);

    // R12 / R2: strobe and ready during a live read burst, then R1 reset mid-burst
    @(negedge clk);
    req_addr_i = 16'h0500; req_len_i = 2'd3; req_wrap_i = 1'b0; req_write_i = 1'b0;
    cfg_page_i = 2'd3; cfg_gap_i = 4'd3; cfg_wait_en_i = 1'b0;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_oe_no && mem_we_no && !mem_cs_no, "R12 read strobe only",
        int'({mem_oe_no, mem_we_no}), 1);
    chk(!req_ready_o && busy_o, "R2 not ready while busy", int'(req_ready_o), 0);
    rst_ni = 1'b0;
    #1;
    chk(mem_cs_no && mem_oe_no && mem_we_no && mem_adv_no && req_ready_o && !busy_o,
        "R1 reset mid-burst", int'({mem_cs_no, mem_oe_no, req_ready_o, busy_o}), 14);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule